// File: doc/BRIEF.md
# Serial Display-Memory Write Parser

This block is a write-only serial slave. It turns a byte stream from a host into single-byte writes on a display and control memory. The memory is addressed as 11 rows of 32 columns. Nine address bits reach the memory as the row number followed by the five-bit column number. The serial pins are sampled in the system clock domain through synchronizer chains. Bits are gathered on the rising serial clock edge while the select line is low.

The stream carries three kinds of byte. A row address has its top bit set. A column address has its top bit clear. An information byte is the data to store. The host can send row, column and data every time. It can also set a row once and then send column/data pairs. Or it can set a starting row and column with the streaming flag and send only data after that. In streaming mode the location steps forward one column per data byte, and it moves to column 0 of the next row after column 31. Streaming lasts until the select line goes high.

Only some locations exist:
- rows 0 to 9: character columns 0 to 23 and row-control columns 30 and 31;
- row 10: columns 0 to 12.

Writes aimed at any other location, including the filler columns passed over while streaming, are dropped.

Top module: `osd_spi_loader`

## Requirements
- R1: While `spi_cs_n` is low, a bit is taken from `spi_mosi` on each rising edge of `spi_sck`. Eight bits make one byte, and the first bit received is bit 7.
- R2: When a row address is expected, a byte with bit 7 = 1 is a row address, and its bits 3:0 give the row number.
- R3: When a column address is expected, a byte with bit 7 = 0 is a column address, and its bits 4:0 give the column. If bit 6 is 1 the parser enters streaming mode; if bit 6 is 0, exactly one information byte follows. A byte with bit 7 = 1 in this position replaces the row instead.
- R4: In the non-streaming formats, an information byte is written to the current row and column. The byte after it is a new row address if bit 7 = 1, and a new column address (row kept) otherwise.
- R5: In streaming mode, every byte is written as data whatever its bit 7 and bit 6. After each byte the column goes up by one, and column 31 is followed by column 0 of the next row.
- R6: Streaming mode is left only when `spi_cs_n` goes high. The next transfer starts again from a row address.
- R7: Raising `spi_cs_n` part-way through a byte discards the bits received so far.
- R8: While a row address is expected, a byte with bit 7 = 0 is ignored and produces no write.
- R9: A write is issued only to rows 0–9, columns 0–23 or 30–31, or to row 10, columns 0–12. Every other write is dropped with `ram_we` held low.
- R10: Each accepted write is a one-cycle `ram_we` pulse. `ram_addr` = row×32 + column and `ram_wdata` = the information byte. `ram_we` is low out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| ram_we | output | 1 | Memory write strobe |
| ram_addr | output | 9 | Memory address {row, column} |
| ram_wdata | output | 8 | Memory write data |

## Verification
The assertions assume that the serial clock is slow compared with `clk`: each half period of `spi_sck` lasts several system cycles. Under that assumption two byte-complete events can never fall on neighbouring cycles, so a write strobe is always followed by a cycle without one. They also assume that `spi_cs_n` stays low for a few cycles after the last falling edge of `spi_sck`, so a finished byte is parsed before the select line is released. The stimulus meets both conditions: each serial half period is four system cycles, and every select edge is padded with idle cycles on both sides. Only the abort scenario raises the select line in the middle of a byte, and it does so on purpose.

// File: rtl/osd_ldr_pkg.sv
package osd_ldr_pkg;
   typedef enum logic [1:0] {
      PS_ROW    = 2'd0,
      PS_COL    = 2'd1,
      PS_INFO   = 2'd2,
      PS_STREAM = 2'd3
   } parse_state_t;
endpackage

// File: rtl/osd_bit_sync.sv
module osd_bit_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{RST_VAL}};
            else        q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/osd_spi_deser.sv
module osd_spi_deser #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              mosi,
   output logic              sel_n,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic sck_s, mosi_s, sck_prev, sck_rise;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] shreg;

   osd_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs
      (.clk(clk), .rst_n(rst_n), .din(cs_n), .dout(sel_n));
   osd_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck
      (.clk(clk), .rst_n(rst_n), .din(sck), .dout(sck_s));
   osd_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi
      (.clk(clk), .rst_n(rst_n), .din(mosi), .dout(mosi_s));

   assign sck_rise = sck_s & ~sck_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev   <= 1'b0;
         bit_cnt    <= '0;
         shreg      <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         sck_prev   <= sck_s;
         byte_valid <= 1'b0;
         if (sel_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[DATA_W-3:0], mosi_s};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt    <= '0;
               byte_valid <= 1'b1;
               byte_data  <= {shreg, mosi_s};
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/osd_pkt_parser.sv
module osd_pkt_parser
   import osd_ldr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ROW_W  = 4,
   parameter int COL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   output parse_state_t      state,
   output logic              wr_req,
   output logic [ROW_W-1:0]  wr_row,
   output logic [COL_W-1:0]  wr_col,
   output logic [DATA_W-1:0] wr_data
);
   localparam int ROW_FLAG   = DATA_W - 1;
   localparam int STREAM_BIT = DATA_W - 2;

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;

   assign wr_req  = byte_valid && !sel_n && (state == PS_INFO || state == PS_STREAM);
   assign wr_row  = row_q;
   assign wr_col  = col_q;
   assign wr_data = byte_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PS_ROW;
         row_q <= '0;
         col_q <= '0;
      end else if (sel_n) begin
         state <= PS_ROW;
      end else if (byte_valid) begin
         case (state)
            PS_ROW: begin
               if (byte_data[ROW_FLAG]) begin
                  row_q <= byte_data[ROW_W-1:0];
                  state <= PS_COL;
               end
            end
            PS_COL: begin
               if (byte_data[ROW_FLAG]) begin
                  row_q <= byte_data[ROW_W-1:0];
               end else begin
                  col_q <= byte_data[COL_W-1:0];
                  state <= byte_data[STREAM_BIT] ? PS_STREAM : PS_INFO;
               end
            end
            PS_INFO: state <= PS_COL;
            PS_STREAM: begin
               col_q <= col_q + 1'b1;
               if (&col_q) row_q <= row_q + 1'b1;
            end
            default: state <= PS_ROW;
         endcase
      end
   end
endmodule

// File: rtl/osd_ram_wport.sv
module osd_ram_wport #(
   parameter int DATA_W        = 8,
   parameter int ROW_W         = 4,
   parameter int COL_W         = 5,
   parameter int NUM_ROWS      = 11,
   parameter int CHAR_COLS     = 24,
   parameter int CTRL_COL_LO   = 30,
   parameter int CTRL_ROW_COLS = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_req,
   input  logic [ROW_W-1:0]       wr_row,
   input  logic [COL_W-1:0]       wr_col,
   input  logic [DATA_W-1:0]      wr_data,
   output logic                   ram_we,
   output logic [ROW_W+COL_W-1:0] ram_addr,
   output logic [DATA_W-1:0]      ram_wdata
);
   localparam int LAST_ROW = NUM_ROWS - 1;

   logic present;

   always_comb begin
      if (int'(wr_row) < LAST_ROW)
         present = (int'(wr_col) < CHAR_COLS) || (int'(wr_col) >= CTRL_COL_LO);
      else if (int'(wr_row) == LAST_ROW)
         present = int'(wr_col) < CTRL_ROW_COLS;
      else
         present = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
      end else begin
         ram_we <= wr_req && present;
         if (wr_req && present) begin
            ram_addr  <= {wr_row, wr_col};
            ram_wdata <= wr_data;
         end
      end
   end
endmodule

// File: rtl/osd_spi_loader.sv
module osd_spi_loader
   import osd_ldr_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ROW_W         = 4,
   parameter int COL_W         = 5,
   parameter int NUM_ROWS      = 11,
   parameter int CHAR_COLS     = 24,
   parameter int CTRL_COL_LO   = 30,
   parameter int CTRL_ROW_COLS = 13,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   spi_cs_n,
   input  logic                   spi_sck,
   input  logic                   spi_mosi,
   output logic                   ram_we,
   output logic [ROW_W+COL_W-1:0] ram_addr,
   output logic [DATA_W-1:0]      ram_wdata
);
   localparam int NUM_COLS = 1 << COL_W;

   generate
      if (COL_W + 2 > DATA_W) begin : g_bad_col
         $error("column field and two flag bits must fit in a byte");
      end
      if (ROW_W + 1 > DATA_W) begin : g_bad_row
         $error("row field and row flag must fit in a byte");
      end
      if (NUM_ROWS > (1 << ROW_W) || NUM_ROWS < 2) begin : g_bad_rows
         $error("NUM_ROWS out of range for ROW_W");
      end
      if (CHAR_COLS > CTRL_COL_LO || CTRL_COL_LO > NUM_COLS) begin : g_bad_cols
         $error("column regions inconsistent");
      end
      if (CTRL_ROW_COLS > NUM_COLS) begin : g_bad_ctrl
         $error("control row wider than a row");
      end
   endgenerate

   logic              sel_n_s;
   logic              byte_vld;
   logic [DATA_W-1:0] byte_dat;
   parse_state_t      parse_state;
   logic              wr_req;
   logic [ROW_W-1:0]  wr_row;
   logic [COL_W-1:0]  wr_col;
   logic [DATA_W-1:0] wr_data;

   osd_spi_deser #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_deser (
      .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
      .sel_n(sel_n_s), .byte_valid(byte_vld), .byte_data(byte_dat));

   osd_pkt_parser #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_parse (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n_s), .byte_valid(byte_vld),
      .byte_data(byte_dat), .state(parse_state), .wr_req(wr_req),
      .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data));

   osd_ram_wport #(
      .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .NUM_ROWS(NUM_ROWS),
      .CHAR_COLS(CHAR_COLS), .CTRL_COL_LO(CTRL_COL_LO), .CTRL_ROW_COLS(CTRL_ROW_COLS)
   ) u_wport (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_row(wr_row), .wr_col(wr_col),
      .wr_data(wr_data), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));
endmodule

// File: rtl/osd_spi_loader_chk.sv
module osd_spi_loader_chk
   import osd_ldr_pkg::*;
#(
   parameter int ROW_W         = 4,
   parameter int COL_W         = 5,
   parameter int NUM_ROWS      = 11,
   parameter int CHAR_COLS     = 24,
   parameter int CTRL_COL_LO   = 30,
   parameter int CTRL_ROW_COLS = 13
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sel_n,
   input logic                   byte_valid,
   input parse_state_t           state,
   input logic                   ram_we,
   input logic [ROW_W+COL_W-1:0] ram_addr
);
   logic [ROW_W-1:0] a_row;
   logic [COL_W-1:0] a_col;
   logic             loc_ok;

   assign a_row  = ram_addr[ROW_W+COL_W-1:COL_W];
   assign a_col  = ram_addr[COL_W-1:0];
   assign loc_ok = (int'(a_row) < NUM_ROWS - 1) ?
                      ((int'(a_col) < CHAR_COLS) || (int'(a_col) >= CTRL_COL_LO)) :
                   (int'(a_row) == NUM_ROWS - 1) ? (int'(a_col) < CTRL_ROW_COLS) : 1'b0;

   a_r10_we_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(byte_valid));

   a_r10_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we);

   a_r9_only_present_locs: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> loc_ok);

   a_r6_stream_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_STREAM && !sel_n) |=> state == PS_STREAM);

   a_r7_deselect_idles: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> state == PS_ROW);
endmodule

bind osd_spi_loader osd_spi_loader_chk #(
   .ROW_W(ROW_W), .COL_W(COL_W), .NUM_ROWS(NUM_ROWS), .CHAR_COLS(CHAR_COLS),
   .CTRL_COL_LO(CTRL_COL_LO), .CTRL_ROW_COLS(CTRL_ROW_COLS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_n(sel_n_s), .byte_valid(byte_vld),
   .state(parse_state), .ram_we(ram_we), .ram_addr(ram_addr));

// File: tb/osd_spi_loader_bench.sv
`timescale 1ns/1ps
module osd_spi_loader_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic       mosi = 1'b0;
   logic       ram_we;
   logic [8:0] ram_addr;
   logic [7:0] ram_wdata;

   int n_checks = 0;
   int n_fail   = 0;
   int wr_cnt   = 0;
   bit done     = 0;
   logic [7:0] seen [0:511];
   logic [8:0] last_addr = '0;

   always #4 clk = ~clk;

   osd_spi_loader u_osd_spi_loader (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

   always @(negedge clk) begin
      if (rst_n && ram_we) begin
         seen[ram_addr] <= ram_wdata;
         last_addr      <= ram_addr;
         wr_cnt         <= wr_cnt + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int loc(input int r, input int c);
      return r * 32 + c;
   endfunction

   task automatic spi_bits(input logic [7:0] b, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk) mosi = b[i];
         repeat (4) @(negedge clk);
         sck = 1'b1;
         repeat (4) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic spi_byte(input logic [7:0] b);
      spi_bits(b, 8);
   endtask

   task automatic sel;
      @(negedge clk) cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic desel;
      repeat (6) @(negedge clk);
      cs_n = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R10 reset we", int'(ram_we), 0);
      chk("R10 reset writes", wr_cnt, 0);
   endtask

   task automatic t_format_a;
      int base = wr_cnt;
      sel();
      spi_byte(8'h82); spi_byte(8'h05); spi_byte(8'h41);
      spi_byte(8'h83); spi_byte(8'h07); spi_byte(8'h42);
      desel();
      chk("R1 R2 R4 fmt-a data1", int'(seen[loc(2, 5)]), 'h41);
      chk("R4 fmt-a data2", int'(seen[loc(3, 7)]), 'h42);
      chk("R10 fmt-a last addr", int'(last_addr), loc(3, 7));
      chk("R10 fmt-a pulses", wr_cnt - base, 2);
   endtask

   task automatic t_format_b;
      int base = wr_cnt;
      sel();
      spi_byte(8'h84); spi_byte(8'h00); spi_byte(8'h11);
      spi_byte(8'h01); spi_byte(8'h12);
      spi_byte(8'h1E); spi_byte(8'h13);
      desel();
      chk("R3 fmt-b col0", int'(seen[loc(4, 0)]), 'h11);
      chk("R3 fmt-b col1", int'(seen[loc(4, 1)]), 'h12);
      chk("R3 fmt-b col30", int'(seen[loc(4, 30)]), 'h13);
      chk("R4 fmt-b writes", wr_cnt - base, 3);
   endtask

   task automatic t_stream;
      int base = wr_cnt;
      sel();
      spi_byte(8'h80); spi_byte(8'h56);
      spi_byte(8'hA1); spi_byte(8'h85); spi_byte(8'hC3); spi_byte(8'h77);
      desel();
      chk("R5 stream col22", int'(seen[loc(0, 22)]), 'hA1);
      chk("R6 stream flag byte as data", int'(seen[loc(0, 23)]), 'h85);
      chk("R9 stream filler dropped", wr_cnt - base, 2);
      base = wr_cnt;
      sel();
      spi_byte(8'h89); spi_byte(8'h5E);
      spi_byte(8'h21); spi_byte(8'h22); spi_byte(8'h23);
      desel();
      chk("R5 stream col30", int'(seen[loc(9, 30)]), 'h21);
      chk("R5 stream col31", int'(seen[loc(9, 31)]), 'h22);
      chk("R5 stream row wrap", int'(seen[loc(10, 0)]), 'h23);
      chk("R5 stream wrap writes", wr_cnt - base, 3);
      base = wr_cnt;
      sel();
      spi_byte(8'h81); spi_byte(8'h02); spi_byte(8'h33);
      desel();
      chk("R6 new transfer leaves stream", int'(seen[loc(1, 2)]), 'h33);
      chk("R6 new transfer writes", wr_cnt - base, 1);
   endtask

   task automatic t_abort;
      int base = wr_cnt;
      sel();
      spi_bits(8'h8A, 5);
      desel();
      sel();
      spi_byte(8'h03); spi_byte(8'h66); spi_byte(8'h55);
      desel();
      chk("R7 R8 partial byte and stray bytes", wr_cnt - base, 0);
      base = wr_cnt;
      sel();
      spi_byte(8'h82); spi_byte(8'h06); spi_byte(8'h5A);
      desel();
      chk("R7 recover after abort", int'(seen[loc(2, 6)]), 'h5A);
      chk("R7 recover writes", wr_cnt - base, 1);
   endtask

   task automatic t_drop;
      int base = wr_cnt;
      sel();
      spi_byte(8'h8A); spi_byte(8'h0D); spi_byte(8'h99);
      spi_byte(8'h8B); spi_byte(8'h00); spi_byte(8'h98);
      spi_byte(8'h83); spi_byte(8'h1B); spi_byte(8'h97);
      spi_byte(8'h8A); spi_byte(8'h0C); spi_byte(8'h96);
      spi_byte(8'h89); spi_byte(8'h17); spi_byte(8'h95);
      desel();
      chk("R9 missing locations dropped", wr_cnt - base, 2);
      chk("R9 row10 col12 kept", int'(seen[loc(10, 12)]), 'h96);
      chk("R9 row9 col23 kept", int'(seen[loc(9, 23)]), 'h95);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 512; i++) seen[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_format_a();
      t_format_b();
      t_stream();
      t_abort();
      t_drop();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule